// File: doc/BRIEF.md
# Accumulator Scalar ALU

This block is the arithmetic and logic engine of a small accumulator machine. It holds three 32-bit working registers (A, X, Y) plus a Carry and a Zero flag. Each cycle with `op_valid` high, it selects two operands from the registers, a constant zero or a zero-extended 16-bit immediate. It then performs one of fourteen arithmetic, logic, shift or rotate operations, writes the result to the chosen register (or discards it), and updates both flags.

The same operand selectors also feed a separate adder. That adder presents the sum of the two selected sources on `ea_out` every cycle, so the surrounding control logic can compute effective addresses for loads, stores and jumps. When no operation is issued, a flag command can force Carry or Zero to a given value.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, A, X, Y, `carry` and `zero` are all zero after the next rising clock edge.
- R2: First-source code 00 selects constant zero, 01 A, 10 X, 11 Y. Second-source code 00 selects `imm` zero-extended to 32 bits, 01 A, 10 X, 11 Y.
- R3: Destination code 01 writes A, 10 writes X, 11 writes Y, and 00 writes no register. Only the addressed register changes.
- R4: Operation 0000 computes first + second and 0001 computes first + second + carry. Carry takes the bit-32 carry-out.
- R5: Operation 0010 computes first − second and 0011 computes first − second − carry. Carry becomes 1 exactly when the true difference is negative (borrow).
- R6: Operation 0100 computes first + 1 and 0110 computes first − 1, ignoring the second source. Carry takes the carry-out or the borrow. Codes 0101 and 0111 behave as 0100 and 0110.
- R7: Operation 1000 gives AND, 1001 OR and 1010 XOR. Operation 1011 (multiply, not built) gives 0. All four leave carry unchanged.
- R8: Operation 1100 shifts the first source left by one and 1110 shifts it right by one, inserting 0. Carry takes the bit shifted out.
- R9: Operation 1101 rotates the first source left and 1111 rotates it right through carry. The old carry enters the vacated bit, and the bit shifted out becomes the new carry.
- R10: For every operation, Zero becomes 1 exactly when the 32-bit result is zero. This holds even when the destination code is 00.
- R11: With `op_valid` low and `flag_cmd` high, the flag named by `flag_tgt` (0 = carry, 1 = zero) takes `flag_val`. With `op_valid` high, `flag_cmd` has no effect.
- R12: `ea_out` always equals first + second (modulo 2^32) for the current selector and immediate inputs, independent of `op_valid`.
- R13: With `op_valid` and `flag_cmd` both low, no register or flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Execute the operation this cycle |
| op_code | input | 4 | Operation code |
| dst_sel | input | 2 | Destination register code |
| src1_sel | input | 2 | First-source code |
| src2_sel | input | 2 | Second-source code |
| imm | input | 16 | Immediate value |
| flag_cmd | input | 1 | Force a flag (when no operation is issued) |
| flag_tgt | input | 1 | Flag to force: 0 carry, 1 zero |
| flag_val | input | 1 | Value to force |
| ea_out | output | 32 | Sum of the selected sources |
| reg_a | output | 32 | Register A |
| reg_x | output | 32 | Register X |
| reg_y | output | 32 | Register Y |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |

## Verification
The hardest conditions to reach are the carry-dependent paths. These are rotates entering a 1, ADC and SBC with carry set, and SBC with equal operands, where only the incoming carry produces a borrow. A further hard case is a flag command that collides with an issued operation. A directed preamble reaches them first. It builds all-ones and zero values through DEC and ADD, and forces carry with flag commands just before the rotate and subtract-with-borrow cases. Several thousand random cycles then mix every code, selector and collision. A behavioural model in the bench compares all registers, both flags and the address sum on every clock.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'b0000,
        OP_ADC = 4'b0001,
        OP_SUB = 4'b0010,
        OP_SBC = 4'b0011,
        OP_INC = 4'b0100,
        OP_DEC = 4'b0110,
        OP_AND = 4'b1000,
        OP_OR  = 4'b1001,
        OP_XOR = 4'b1010,
        OP_MUL = 4'b1011,
        OP_LSL = 4'b1100,
        OP_ROL = 4'b1101,
        OP_LSR = 4'b1110,
        OP_ROR = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_A    = 2'b01,
        SEL_X    = 2'b10,
        SEL_Y    = 2'b11
    } reg_sel_e;

endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] zero_val,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_x,
    input  logic [DATA_W-1:0] reg_y,
    output logic [DATA_W-1:0] opnd
);
    import acc_alu_pkg::*;

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_A:   opnd = reg_a;
            SEL_X:   opnd = reg_x;
            SEL_Y:   opnd = reg_y;
            default: opnd = zero_val;
        endcase
    end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd1,
    input  logic [DATA_W-1:0] opnd2,
    input  logic              cin,
    output logic [DATA_W-1:0] result,
    output logic              cout
);
    import acc_alu_pkg::*;

    localparam int unsigned EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext1, ext2, ext_c, ext_one, wide;

    assign ext1    = {1'b0, opnd1};
    assign ext2    = {1'b0, opnd2};
    assign ext_c   = {{DATA_W{1'b0}}, cin};
    assign ext_one = {{DATA_W{1'b0}}, 1'b1};

    always_comb begin
        wide   = '0;
        result = '0;
        cout   = cin;
        unique casez (op_code)
            4'b0000: wide = ext1 + ext2;
            4'b0001: wide = ext1 + ext2 + ext_c;
            4'b0010: wide = ext1 - ext2;
            4'b0011: wide = ext1 - ext2 - ext_c;
            4'b010?: wide = ext1 + ext_one;
            4'b011?: wide = ext1 - ext_one;
            default: wide = '0;
        endcase
        if (op_code[3] == 1'b0) begin
            result = wide[DATA_W-1:0];
            cout   = wide[DATA_W];
        end else begin
            unique case (alu_op_e'(op_code))
                OP_AND: result = opnd1 & opnd2;
                OP_OR:  result = opnd1 | opnd2;
                OP_XOR: result = opnd1 ^ opnd2;
                OP_MUL: result = '0;
                OP_LSL: begin
                    result = {opnd1[DATA_W-2:0], 1'b0};
                    cout   = opnd1[DATA_W-1];
                end
                OP_ROL: begin
                    result = {opnd1[DATA_W-2:0], cin};
                    cout   = opnd1[DATA_W-1];
                end
                OP_LSR: begin
                    result = {1'b0, opnd1[DATA_W-1:1]};
                    cout   = opnd1[0];
                end
                OP_ROR: begin
                    result = {cin, opnd1[DATA_W-1:1]};
                    cout   = opnd1[0];
                end
                default: result = '0;
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_agen.sv
module acc_alu_agen #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    output logic [DATA_W-1:0] addr
);
    always_comb addr = base + offset;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [1:0]        dst_sel,
    input  logic [1:0]        src1_sel,
    input  logic [1:0]        src2_sel,
    input  logic [IMM_W-1:0]  imm,
    input  logic              flag_cmd,
    input  logic              flag_tgt,
    input  logic              flag_val,
    output logic [DATA_W-1:0] ea_out,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_x,
    output logic [DATA_W-1:0] reg_y,
    output logic              carry,
    output logic              zero
);
    import acc_alu_pkg::*;

    localparam int unsigned N_OPND = 2;
    localparam int unsigned PAD_W  = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic              c;
        logic              z;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd   [N_OPND];
    logic [DATA_W-1:0] zval   [N_OPND];
    logic [1:0]        selv   [N_OPND];
    logic [DATA_W-1:0] alu_res;
    logic              alu_cout;

    assign imm_ext = {{PAD_W{1'b0}}, imm};
    assign selv[0] = src1_sel;
    assign selv[1] = src2_sel;
    assign zval[0] = '0;
    assign zval[1] = imm_ext;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
        acc_alu_opsel #(.DATA_W(DATA_W)) u_sel (
            .sel      (selv[gi]),
            .zero_val (zval[gi]),
            .reg_a    (st_q.a),
            .reg_x    (st_q.x),
            .reg_y    (st_q.y),
            .opnd     (opnd[gi])
        );
    end

    acc_alu_exec #(.DATA_W(DATA_W)) u_exec (
        .op_code (op_code),
        .opnd1   (opnd[0]),
        .opnd2   (opnd[1]),
        .cin     (st_q.c),
        .result  (alu_res),
        .cout    (alu_cout)
    );

    acc_alu_agen #(.DATA_W(DATA_W)) u_agen (
        .base   (opnd[0]),
        .offset (opnd[1]),
        .addr   (ea_out)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            st_d.c = alu_cout;
            st_d.z = (alu_res == '0);
            unique case (reg_sel_e'(dst_sel))
                SEL_A:   st_d.a = alu_res;
                SEL_X:   st_d.x = alu_res;
                SEL_Y:   st_d.y = alu_res;
                default: ;
            endcase
        end else if (flag_cmd) begin
            if (flag_tgt) st_d.z = flag_val;
            else          st_d.c = flag_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_a = st_q.a;
    assign reg_x = st_q.x;
    assign reg_y = st_q.y;
    assign carry = st_q.c;
    assign zero  = st_q.z;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [1:0]        dst_sel,
    input logic [1:0]        src1_sel,
    input logic [1:0]        src2_sel,
    input logic [IMM_W-1:0]  imm,
    input logic              flag_cmd,
    input logic              flag_tgt,
    input logic              flag_val,
    input logic [DATA_W-1:0] ea_out,
    input logic [DATA_W-1:0] reg_a,
    input logic [DATA_W-1:0] reg_y,
    input logic              carry,
    input logic              zero
);
    localparam int unsigned PAD_W = DATA_W - IMM_W;

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !flag_cmd) |=> ($stable(reg_a) && $stable(reg_y) && $stable(carry) && $stable(zero)));

    // R3
    no_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dst_sel == 2'b00) |=> ($stable(reg_a) && $stable(reg_y)));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dst_sel == 2'b01) |=> (zero == (reg_a == '0)));

    // R11
    force_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && flag_cmd && !flag_tgt) |=> (carry == $past(flag_val)));

    // R11
    force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && flag_cmd && flag_tgt) |=> (zero == $past(flag_val)));

    // R8
    shl_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'b1100 && src1_sel == 2'b01 && dst_sel == 2'b01)
        |=> (reg_a == {$past(reg_a[DATA_W-2:0]), 1'b0} && carry == $past(reg_a[DATA_W-1])));

    // R9
    ror_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'b1111 && src1_sel == 2'b11 && dst_sel == 2'b11)
        |=> (reg_y == {$past(carry), $past(reg_y[DATA_W-1:1])} && carry == $past(reg_y[0])));

    // R12
    imm_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src1_sel == 2'b00 && src2_sel == 2'b00) |-> (ea_out == {{PAD_W{1'b0}}, imm}));
endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .dst_sel  (dst_sel),
    .src1_sel (src1_sel),
    .src2_sel (src2_sel),
    .imm      (imm),
    .flag_cmd (flag_cmd),
    .flag_tgt (flag_tgt),
    .flag_val (flag_val),
    .ea_out   (ea_out),
    .reg_a    (reg_a),
    .reg_y    (reg_y),
    .carry    (carry),
    .zero     (zero)
);

// File: tb/acc_alu_core_test.sv
module acc_alu_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [1:0]  dst_sel, src1_sel, src2_sel;
    logic [15:0] imm;
    logic        flag_cmd, flag_tgt, flag_val;
    logic [31:0] ea_out, reg_a, reg_x, reg_y;
    logic        carry, zero;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] ma, mx, my;
    logic        mc, mz;

    always #5 clk = ~clk;

    acc_alu_core uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .dst_sel(dst_sel), .src1_sel(src1_sel), .src2_sel(src2_sel), .imm(imm),
        .flag_cmd(flag_cmd), .flag_tgt(flag_tgt), .flag_val(flag_val),
        .ea_out(ea_out), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
        .carry(carry), .zero(zero)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] pick(input logic [1:0] s, input logic second, input logic [15:0] iv);
        case (s)
            2'd1: return ma;
            2'd2: return mx;
            2'd3: return my;
            default: return second ? {16'h0, iv} : 32'h0;
        endcase
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        if (op <= 4'd1) return "R4";
        if (op <= 4'd3) return "R5";
        if (op <= 4'd7) return "R6";
        if (op <= 4'd11) return "R7";
        if (op == 4'd12 || op == 4'd14) return "R8";
        return "R9";
    endfunction

    task automatic apply(input logic v, input logic [3:0] op, input logic [1:0] d,
                         input logic [1:0] s1, input logic [1:0] s2, input logic [15:0] iv,
                         input logic fc, input logic ft, input logic fv);
        logic [31:0] a, b, r;
        logic [32:0] t;
        logic        co;
        string       tg;
        op_valid = v; op_code = op; dst_sel = d; src1_sel = s1; src2_sel = s2;
        imm = iv; flag_cmd = fc; flag_tgt = ft; flag_val = fv;
        #1;
        a = pick(s1, 1'b0, iv);
        b = pick(s2, 1'b1, iv);
        chk("R12 R2 ea_out", ea_out, a + b);
        co = mc; r = 32'h0; t = 33'h0;
        case (op)
            4'd0: t = {1'b0, a} + {1'b0, b};
            4'd1: t = {1'b0, a} + {1'b0, b} + {32'h0, mc};
            4'd2: t = {1'b0, a} - {1'b0, b};
            4'd3: t = {1'b0, a} - {1'b0, b} - {32'h0, mc};
            4'd4, 4'd5: t = {1'b0, a} + 33'd1;
            4'd6, 4'd7: t = {1'b0, a} - 33'd1;
            default: t = 33'h0;
        endcase
        if (op < 4'd8) begin r = t[31:0]; co = t[32]; end
        else case (op)
            4'd8:  r = a & b;
            4'd9:  r = a | b;
            4'd10: r = a ^ b;
            4'd11: r = 32'h0;
            4'd12: begin r = a << 1; co = a[31]; end
            4'd13: begin r = (a << 1) | {31'h0, mc}; co = a[31]; end
            4'd14: begin r = a >> 1; co = a[0]; end
            default: begin r = (a >> 1) | {mc, 31'h0}; co = a[0]; end
        endcase
        if (v) begin
            tg = op_tag(op);
            mc = co;
            mz = (r == 32'h0);
            if (d == 2'd1) ma = r;
            if (d == 2'd2) mx = r;
            if (d == 2'd3) my = r;
        end else if (fc) begin
            tg = "R11";
            if (ft) mz = fv; else mc = fv;
        end else tg = "R13";
        @(posedge clk);
        #2;
        chk({tg, " R3 reg_a"}, reg_a, ma);
        chk({tg, " R3 reg_x"}, reg_x, mx);
        chk({tg, " R3 reg_y"}, reg_y, my);
        chk({tg, " carry"}, {31'h0, carry}, {31'h0, mc});
        chk({tg, " R10 zero"}, {31'h0, zero}, {31'h0, mz});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        op_valid = 1'b1; op_code = 4'd4; dst_sel = 2'd1; src1_sel = 2'd0; src2_sel = 2'd0;
        imm = 16'h0; flag_cmd = 1'b0; flag_tgt = 1'b0; flag_val = 1'b0;
        ma = 0; mx = 0; my = 0; mc = 0; mz = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset dominates an issued operation
        chk("R1 reg_a", reg_a, 32'h0);
        chk("R1 reg_x", reg_x, 32'h0);
        chk("R1 reg_y", reg_y, 32'h0);
        chk("R1 flags", {30'h0, carry, zero}, 32'h0);
        rst_n = 1'b1;

        apply(1, 4'd0, 2'd1, 2'd0, 2'd0, 16'h1234, 0, 0, 0);   // R2 A = imm
        apply(1, 4'd0, 2'd2, 2'd1, 2'd0, 16'hFFFF, 0, 0, 0);   // R4 X = A + imm
        apply(1, 4'd6, 2'd3, 2'd0, 2'd2, 16'h0, 0, 0, 0);      // R6 Y = 0 - 1, borrow
        apply(1, 4'd0, 2'd1, 2'd3, 2'd0, 16'h0001, 0, 0, 0);   // R4 all-ones + 1 -> 0, carry
        apply(1, 4'd1, 2'd0, 2'd1, 2'd0, 16'h0000, 0, 0, 0);   // R4 R10 ADC, no dest
        apply(1, 4'd2, 2'd0, 2'd2, 2'd2, 16'h0, 0, 0, 0);      // R5 equal -> zero, no borrow
        apply(0, 4'd0, 2'd0, 2'd0, 2'd0, 16'h0, 1, 0, 1);      // R11 set carry
        apply(1, 4'd3, 2'd0, 2'd2, 2'd2, 16'h0, 0, 0, 0);      // R5 equal minus carry -> borrow
        apply(1, 4'd3, 2'd1, 2'd2, 2'd0, 16'h0005, 0, 0, 0);   // R5 SBC with borrow in
        apply(0, 4'd0, 2'd0, 2'd0, 2'd0, 16'h0, 1, 1, 1);      // R11 set zero
        apply(0, 4'd0, 2'd0, 2'd0, 2'd0, 16'h0, 1, 1, 0);      // R11 clear zero
        apply(1, 4'd8, 2'd1, 2'd3, 2'd0, 16'h00F0, 1, 0, 0);   // R11 ignored, R7 AND
        apply(0, 4'd0, 2'd0, 2'd0, 2'd0, 16'h0, 1, 0, 1);      // set carry
        apply(1, 4'd13, 2'd2, 2'd2, 2'd0, 16'h0, 0, 0, 0);     // R9 ROL carry in
        apply(1, 4'd15, 2'd3, 2'd3, 2'd0, 16'h0, 0, 0, 0);     // R9 ROR
        apply(1, 4'd12, 2'd1, 2'd1, 2'd2, 16'h0, 0, 0, 0);     // R8 LSL
        apply(1, 4'd14, 2'd2, 2'd3, 2'd0, 16'h0, 0, 0, 0);     // R8 LSR
        apply(1, 4'd5, 2'd1, 2'd3, 2'd1, 16'h0, 0, 0, 0);      // R6 code 0101 as INC
        apply(1, 4'd7, 2'd2, 2'd0, 2'd3, 16'h0, 0, 0, 0);      // R6 code 0111 as DEC
        apply(1, 4'd11, 2'd3, 2'd1, 2'd2, 16'h0, 0, 0, 0);     // R7 MUL -> 0
        apply(1, 4'd9, 2'd1, 2'd2, 2'd0, 16'hA5A5, 0, 0, 0);   // R7 OR
        apply(1, 4'd10, 2'd3, 2'd1, 2'd2, 16'h0, 0, 0, 0);     // R7 XOR
        apply(0, 4'd0, 2'd1, 2'd1, 2'd3, 16'h7777, 0, 0, 0);   // R13 idle

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            apply(rv[1:0] != 2'b00, rv[5:2], rv[7:6], rv[9:8], rv[11:10],
                  rv[27:12], rv[28], rv[29], rv[30]);
        end
        finish_run();
    end
endmodule